// File: doc/BRIEF.md
# Branch Resolution Unit

This block settles where the instruction stream goes after a control-transfer instruction. Each cycle it is offered an instruction word, the address of that instruction and the four condition flags. It also has one register-file read port. It recognises two classes of instruction:

- **Register-indirect jump.** The next address is the value of a general register.
- **PC-relative branch.** The branch may carry a condition and a request to save a return address.

For either class the block gives the next program counter in the same cycle. When a linking branch is taken, it also gives a write to the link register.

Any other instruction is treated as ordinary sequential flow. For those the block returns the address four bytes on, and it counts nothing.

A registered taken indication and a wrapping count of resolved control instructions appear one clock after the instruction is offered. A branch whose condition fails still counts as a resolved control instruction.

Top module: `branch_resolve_unit`

## Requirements
- R1: An instruction whose bits 27:4 equal 0x12FFF1 is a register jump, whatever its bits 31:28 hold. `rs_idx_o` equals its bits 3:0, and `next_pc_o` equals `rs_data_i`. It is always taken and never writes the link register.
- R2: An instruction whose bits 27:25 equal 101 is a relative branch. When it is taken, `next_pc_o` = `pc_i` + 8 + (sign-extended bits 23:0 × 4), modulo 2^32.
- R3: For a relative branch, condition code 0000 is taken only when Z is 1. Code 0001 is taken only when Z is 0. The condition code is bits 31:28.
- R4: `flags_i` bit 3 is N, bit 2 is Z, bit 1 is C and bit 0 is V. The remaining codes mean the following:
  - 0010: C
  - 0011: !C
  - 0100: N
  - 0101: !N
  - 0110: V
  - 0111: !V
  - 1000: C & !Z
  - 1001: !C | Z
  - 1010: N == V
  - 1011: N != V
  - 1100: !Z & (N == V)
  - 1101: Z | (N != V)
- R5: Code 1110 is always taken. Code 1111 is never taken.
- R6: A relative branch whose condition fails gives `next_pc_o` = `pc_i` + 4.
- R7: A relative branch with bit 24 set that is taken asserts `lr_we_o`, with `lr_data_o` = `pc_i` + 4. The link register is not written when bit 24 is clear, when the branch is not taken, or when `valid_i` is low.
- R8: Any other instruction, or any cycle with `valid_i` low, gives the following: `is_ctrl_o` low, `next_pc_o` = `pc_i` + 4, no link write, and no count.
- R9: `taken_o` shows, one clock after a cycle, whether that cycle held a valid control instruction that was taken.
- R10: `ctrl_cnt_o` goes up by one, one clock after each valid control instruction, whether or not it is taken. It wraps at 2^CNT_W.
- R11: A clock edge with `rst_n` low clears `taken_o` and `ctrl_cnt_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | Instruction word is valid this cycle |
| instr_i | input | XLEN | Instruction word |
| pc_i | input | XLEN | Address of the instruction |
| flags_i | input | 4 | Condition flags N,Z,C,V (bit 3 down to 0) |
| rs_idx_o | output | 4 | Register-file read index |
| rs_data_i | input | XLEN | Register-file read data for rs_idx_o |
| next_pc_o | output | XLEN | Resolved next program counter |
| is_ctrl_o | output | 1 | Valid control instruction present |
| lr_we_o | output | 1 | Link-register write enable |
| lr_data_o | output | XLEN | Return address to write to the link register |
| taken_o | output | 1 | Registered taken indication |
| ctrl_cnt_o | output | CNT_W | Registered count of resolved control instructions |

## Verification
These outputs are combinational and are valid in the same cycle as the instruction: `rs_idx_o`, `next_pc_o`, `is_ctrl_o`, `lr_we_o` and `lr_data_o`. `taken_o` and `ctrl_cnt_o` each pass through a single register, so they are due at the first rising edge after the instruction is presented.

The bench drives each instruction on a falling edge. It samples the combinational results two nanoseconds later, before any rising edge. It then waits for the next rising edge and samples the registered results two nanoseconds after it. The instruction is held through exactly one rising edge, so each registered value belongs to one known instruction.

// File: rtl/bru_pkg.sv
// Package bru_pkg
// Holds the shared decode signatures and the class type of the branch
// resolution unit. It assumes 32-bit instruction words with the class
// bits at fixed positions.
package bru_pkg;

    // Instruction classes recognised by the decoder
    typedef enum logic [1:0] {
        CLS_SEQ  = 2'd0,
        CLS_JREG = 2'd1,
        CLS_REL  = 2'd2
    } brclass_e;

    localparam int          INSTR_W  = 32;
    localparam int          OFF_W    = 24;
    localparam logic [23:0] JREG_SIG = 24'h12FFF1;   // bits 27:4
    localparam logic [2:0]  REL_SIG  = 3'b101;       // bits 27:25

endpackage

// File: rtl/bru_decode.sv
// Module bru_decode
// Classifies an instruction word and extracts the branch fields. The
// register jump is matched first because it has the most fixed bits.
// Assumes the fixed class positions defined in bru_pkg.
module bru_decode
    import bru_pkg::*;
(
    input  logic [INSTR_W-1:0] instr_i,
    output brclass_e           cls_o,
    output logic [3:0]         cond_o,
    output logic               link_o,
    output logic [OFF_W-1:0]   off_o,
    output logic [3:0]         reg_o
);

    // Pick the instruction class, most constrained pattern first
    always_comb begin
        if (instr_i[27:4] == JREG_SIG)
            cls_o = CLS_JREG;
        else if (instr_i[27:25] == REL_SIG)
            cls_o = CLS_REL;
        else
            cls_o = CLS_SEQ;
    end

    // Pull out the fixed-position fields
    always_comb begin
        cond_o = instr_i[31:28];
        link_o = instr_i[24];
        off_o  = instr_i[OFF_W-1:0];
        reg_o  = instr_i[3:0];
    end

endmodule

// File: rtl/bru_cond_eval.sv
// Module bru_cond_eval
// Evaluates a 4-bit condition code against the flags, given as
// {N,Z,C,V}. Code 1110 always passes and code 1111 never passes.
module bru_cond_eval (
    input  logic [3:0] cond_i,
    input  logic [3:0] flags_i,
    output logic       pass_o
);

    logic n_f, z_f, c_f, v_f;

    // Split the flag vector into named flags
    always_comb begin
        n_f = flags_i[3];
        z_f = flags_i[2];
        c_f = flags_i[1];
        v_f = flags_i[0];
    end

    // Decode the condition table
    always_comb begin
        unique case (cond_i)
            4'h0: pass_o = z_f;
            4'h1: pass_o = !z_f;
            4'h2: pass_o = c_f;
            4'h3: pass_o = !c_f;
            4'h4: pass_o = n_f;
            4'h5: pass_o = !n_f;
            4'h6: pass_o = v_f;
            4'h7: pass_o = !v_f;
            4'h8: pass_o = c_f && !z_f;
            4'h9: pass_o = !c_f || z_f;
            4'hA: pass_o = (n_f == v_f);
            4'hB: pass_o = (n_f != v_f);
            4'hC: pass_o = !z_f && (n_f == v_f);
            4'hD: pass_o = z_f || (n_f != v_f);
            4'hE: pass_o = 1'b1;
            default: pass_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/bru_target.sv
// Module bru_target
// Computes the sequential address (pc+4) and the relative target
// (pc + 8 + sign-extended word offset). Assumes XLEN > OFF_W + 2.
module bru_target #(
    parameter int XLEN  = 32,
    parameter int OFF_W = 24
) (
    input  logic [XLEN-1:0]  pc_i,
    input  logic [OFF_W-1:0] off_i,
    output logic [XLEN-1:0]  seq_o,
    output logic [XLEN-1:0]  rel_o
);

    localparam int EXT_W = XLEN - OFF_W - 2;

    logic [XLEN-1:0] byte_off;

    // Sign-extend the word offset and scale it to bytes
    always_comb byte_off = {{EXT_W{off_i[OFF_W-1]}}, off_i, 2'b00};

    // Form both candidate addresses
    always_comb begin
        seq_o = pc_i + XLEN'(4);
        rel_o = pc_i + XLEN'(8) + byte_off;
    end

endmodule

// File: rtl/branch_resolve_unit.sv
// Module branch_resolve_unit
// Resolves register jumps and conditional relative branches. It gives
// the next PC and the link write combinationally, and registers the
// taken flag and the control-instruction count. Assumes the register
// file answers rs_idx_o in the same cycle on rs_data_i.
module branch_resolve_unit
    import bru_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic [XLEN-1:0]  instr_i,
    input  logic [XLEN-1:0]  pc_i,
    input  logic [3:0]       flags_i,
    output logic [3:0]       rs_idx_o,
    input  logic [XLEN-1:0]  rs_data_i,
    output logic [XLEN-1:0]  next_pc_o,
    output logic             is_ctrl_o,
    output logic             lr_we_o,
    output logic [XLEN-1:0]  lr_data_o,
    output logic             taken_o,
    output logic [CNT_W-1:0] ctrl_cnt_o
);

    brclass_e         cls;
    logic [3:0]       cond;
    logic             link;
    logic [OFF_W-1:0] off;
    logic [3:0]       reg_sel;
    logic             cond_ok;
    logic [XLEN-1:0]  seq_pc;
    logic [XLEN-1:0]  rel_pc;
    logic             take;

    bru_decode u_dec (
        .instr_i (instr_i[INSTR_W-1:0]),
        .cls_o   (cls),
        .cond_o  (cond),
        .link_o  (link),
        .off_o   (off),
        .reg_o   (reg_sel)
    );

    bru_cond_eval u_cond (
        .cond_i  (cond),
        .flags_i (flags_i),
        .pass_o  (cond_ok)
    );

    bru_target #(.XLEN(XLEN), .OFF_W(OFF_W)) u_tgt (
        .pc_i  (pc_i),
        .off_i (off),
        .seq_o (seq_pc),
        .rel_o (rel_pc)
    );

    // Decide whether a valid control instruction redirects the flow
    always_comb begin
        is_ctrl_o = valid_i && (cls != CLS_SEQ);
        take      = valid_i && ((cls == CLS_JREG) || ((cls == CLS_REL) && cond_ok));
    end

    // Select the next program counter
    always_comb begin
        rs_idx_o = reg_sel;
        if (take && cls == CLS_JREG)
            next_pc_o = rs_data_i;
        else if (take)
            next_pc_o = rel_pc;
        else
            next_pc_o = seq_pc;
    end

    // Link-register write on taken linking branches
    always_comb begin
        lr_we_o   = take && (cls == CLS_REL) && link;
        lr_data_o = seq_pc;
    end

    // Register the taken flag and count control instructions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken_o    <= 1'b0;
            ctrl_cnt_o <= '0;
        end else begin
            taken_o <= take;
            if (is_ctrl_o)
                ctrl_cnt_o <= ctrl_cnt_o + CNT_W'(1);
        end
    end

endmodule

// File: rtl/bru_checks.sv
// Module bru_checks
// Property checker for branch_resolve_unit, attached by bind.
module bru_checks #(
    parameter int XLEN  = 32,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             valid_i,
    input logic [XLEN-1:0]  instr_i,
    input logic [XLEN-1:0]  pc_i,
    input logic [XLEN-1:0]  rs_data_i,
    input logic [XLEN-1:0]  next_pc_o,
    input logic             is_ctrl_o,
    input logic             lr_we_o,
    input logic [XLEN-1:0]  lr_data_o,
    input logic             taken_o,
    input logic [CNT_W-1:0] ctrl_cnt_o
);

    // R1
    jreg_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && instr_i[27:4] == 24'h12FFF1) |-> (next_pc_o == rs_data_i && !lr_we_o));

    // R5
    never_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && instr_i[27:25] == 3'b101 && instr_i[31:28] == 4'hF)
            |-> (next_pc_o == pc_i + XLEN'(4) && !lr_we_o));

    // R7
    link_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lr_we_o |-> (is_ctrl_o && instr_i[24] && lr_data_o == pc_i + XLEN'(4)));

    // R8
    seq_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_ctrl_o |-> (next_pc_o == pc_i + XLEN'(4) && !lr_we_o));

    // R9
    taken_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_ctrl_o |=> !taken_o);

    // R10
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (ctrl_cnt_o == $past(ctrl_cnt_o) + CNT_W'($past(is_ctrl_o))));

endmodule

bind branch_resolve_unit bru_checks #(.XLEN(XLEN), .CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_i    (valid_i),
    .instr_i    (instr_i),
    .pc_i       (pc_i),
    .rs_data_i  (rs_data_i),
    .next_pc_o  (next_pc_o),
    .is_ctrl_o  (is_ctrl_o),
    .lr_we_o    (lr_we_o),
    .lr_data_o  (lr_data_o),
    .taken_o    (taken_o),
    .ctrl_cnt_o (ctrl_cnt_o)
);

// File: tb/branch_resolve_unit_tb.sv
// Directed bench for branch_resolve_unit: one task per scenario.
module branch_resolve_unit_tb_top;

    localparam int XLEN  = 32;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             valid_i = 1'b0;
    logic [XLEN-1:0]  instr_i = '0;
    logic [XLEN-1:0]  pc_i = '0;
    logic [3:0]       flags_i = '0;
    logic [3:0]       rs_idx_o;
    logic [XLEN-1:0]  rs_data_i;
    logic [XLEN-1:0]  next_pc_o;
    logic             is_ctrl_o;
    logic             lr_we_o;
    logic [XLEN-1:0]  lr_data_o;
    logic             taken_o;
    logic [CNT_W-1:0] ctrl_cnt_o;

    int n_chk = 0;
    int n_bad = 0;
    int exp_cnt = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    // Register-file model: register i holds 0x4000_0000 + 0x100*i + 3
    always_comb rs_data_i = 32'h4000_0003 + {20'd0, rs_idx_o, 8'd0};

    branch_resolve_unit #(.XLEN(XLEN), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .instr_i(instr_i),
        .pc_i(pc_i), .flags_i(flags_i), .rs_idx_o(rs_idx_o), .rs_data_i(rs_data_i),
        .next_pc_o(next_pc_o), .is_ctrl_o(is_ctrl_o), .lr_we_o(lr_we_o),
        .lr_data_o(lr_data_o), .taken_o(taken_o), .ctrl_cnt_o(ctrl_cnt_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit cond_model(input logic [3:0] c, input logic [3:0] f);
        bit n = f[3], z = f[2], cy = f[1], v = f[0];
        case (c)
            4'h0: return z;          4'h1: return !z;
            4'h2: return cy;         4'h3: return !cy;
            4'h4: return n;          4'h5: return !n;
            4'h6: return v;          4'h7: return !v;
            4'h8: return cy && !z;   4'h9: return !cy || z;
            4'hA: return n == v;     4'hB: return n != v;
            4'hC: return !z && (n == v);
            4'hD: return z || (n != v);
            4'hE: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // Present one instruction and check both the same-cycle and the registered results
    task automatic apply(input string req, input logic vld, input logic [31:0] ins,
                         input logic [31:0] pc, input logic [3:0] fl,
                         input logic ctrl, input logic tk,
                         input logic [31:0] exp_pc, input logic exp_we);
        @(negedge clk);
        valid_i = vld; instr_i = ins; pc_i = pc; flags_i = fl;
        #2;
        check({req, " next_pc"}, next_pc_o, exp_pc);
        check({req, " is_ctrl"}, {31'd0, is_ctrl_o}, {31'd0, ctrl});
        check({req, " lr_we"}, {31'd0, lr_we_o}, {31'd0, exp_we});
        if (exp_we) check({req, " lr_data"}, lr_data_o, pc + 32'd4);
        if (ctrl) exp_cnt = (exp_cnt + 1) % (1 << CNT_W);
        @(posedge clk); #2;
        check("R9 taken", {31'd0, taken_o}, {31'd0, tk});
        check("R10 count", {16'd0, ctrl_cnt_o}, exp_cnt);
    endtask

    function automatic logic [31:0] rel_ins(input logic [3:0] c, input logic l, input logic [23:0] o);
        return {c, 3'b101, l, o};
    endfunction

    task automatic t_reset;
        @(negedge clk);
        check("R11 taken reset", {31'd0, taken_o}, 32'd0);
        check("R11 count reset", {16'd0, ctrl_cnt_o}, 32'd0);
    endtask

    task automatic t_jreg;
        for (int r = 0; r < 16; r += 5) begin
            logic [31:0] ins = {4'h3, 24'h12FFF1, r[3:0]};
            apply("R1 jump", 1, ins, 32'h0000_2000, 4'h0, 1, 1,
                  32'h4000_0003 + (r << 8), 0);
            check("R1 read index", {28'd0, rs_idx_o}, r);
        end
    endtask

    task automatic t_rel_targets;
        apply("R2 forward", 1, rel_ins(4'hE, 0, 24'h000010), 32'h0000_1000, 4'h0, 1, 1,
              32'h0000_1048, 0);
        apply("R2 backward", 1, rel_ins(4'hE, 0, 24'hFFFFFE), 32'h0000_1000, 4'h0, 1, 1,
              32'h0000_1000, 0);
        apply("R2 max negative", 1, rel_ins(4'hE, 0, 24'h800000), 32'h0400_0000, 4'h0, 1, 1,
              32'h0200_0008, 0);
    endtask

    task automatic t_eq_ne;
        apply("R3 EQ Z=1", 1, rel_ins(4'h0, 0, 24'h4), 32'h100, 4'b0100, 1, 1, 32'h118, 0);
        apply("R3 EQ Z=0 R6", 1, rel_ins(4'h0, 0, 24'h4), 32'h100, 4'b0000, 1, 0, 32'h104, 0);
        apply("R3 NE Z=0", 1, rel_ins(4'h1, 0, 24'h4), 32'h100, 4'b0000, 1, 1, 32'h118, 0);
        apply("R3 NE Z=1 R6", 1, rel_ins(4'h1, 0, 24'h4), 32'h100, 4'b0100, 1, 0, 32'h104, 0);
    endtask

    task automatic t_all_codes;
        for (int c = 0; c < 16; c++) begin
            for (int f = 0; f < 16; f += 3) begin
                bit p = cond_model(c[3:0], f[3:0]);
                apply((c >= 14) ? "R5 AL/never" : "R4 code", 1, rel_ins(c[3:0], 0, 24'h1),
                      32'h800, f[3:0], 1, p, p ? 32'h80C : 32'h804, 0);
            end
        end
    endtask

    task automatic t_link;
        apply("R7 link taken", 1, rel_ins(4'hE, 1, 24'h2), 32'h3000, 4'h0, 1, 1, 32'h3010, 1);
        apply("R7 link not taken", 1, rel_ins(4'h0, 1, 24'h2), 32'h3000, 4'h0, 1, 0, 32'h3004, 0);
        apply("R7 link never", 1, rel_ins(4'hF, 1, 24'h2), 32'h3000, 4'hF, 1, 0, 32'h3004, 0);
        apply("R7 link idle", 0, rel_ins(4'hE, 1, 24'h2), 32'h3000, 4'h0, 0, 0, 32'h3004, 0);
    endtask

    task automatic t_seq;
        apply("R8 data op", 1, 32'hE081_0002, 32'h500, 4'hF, 0, 0, 32'h504, 0);
        apply("R8 load", 1, 32'hE591_0004, 32'h600, 4'h0, 0, 0, 32'h604, 0);
        apply("R8 near jump pattern", 1, 32'hE12F_FF21, 32'h700, 4'h0, 0, 0, 32'h704, 0);
        apply("R8 invalid jump", 0, {4'hE, 24'h12FFF1, 4'h2}, 32'h900, 4'h0, 0, 0, 32'h904, 0);
    endtask

    task automatic t_reset_mid;
        apply("R10 pre", 1, rel_ins(4'hE, 0, 24'h0), 32'h0, 4'h0, 1, 1, 32'h8, 0);
        @(negedge clk); rst_n = 0; valid_i = 1;
        @(posedge clk); #2;
        check("R11 taken cleared", {31'd0, taken_o}, 32'd0);
        check("R11 count cleared", {16'd0, ctrl_cnt_o}, 32'd0);
        exp_cnt = 0;
        @(negedge clk); rst_n = 1; valid_i = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        t_reset();
        @(negedge clk); rst_n = 1;
        t_jreg();
        t_rel_targets();
        t_eq_ne();
        t_all_codes();
        t_link();
        t_seq();
        t_reset_mid();
        @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule